// File: doc/BRIEF.md
# Programmable CRC-32 Engine with Register Access

The block computes a 32-bit cyclic redundancy check over a stream of data words that software writes one at a time through a simple single-cycle register bus. Software first sets a seed and a generator polynomial, then writes a control value. That value reloads the running checksum from the seed and selects how the bits of each input word and of the returned result are ordered. Each following write to the data offset folds one full word into the checksum. A read of the same offset returns the running value.

The polynomial is stored in its normal, non-reflected form. The update runs most significant bit first. To get the reflected variants (the common CRC-32 and the Castagnoli CRC-32C), software bit-reverses the reflected constants before it loads them, sets all three ordering bits, and complements the result itself. The block applies no final XOR.

Top module: `crc32_mmio_engine`

Register offsets (byte addresses): data 0x00, control 0x08, seed 0x10, polynomial 0x14. Control fields: bit 0 is the reload command, bits 6:5 select input ordering, and bit 7 selects output reversal.

## Requirements
- R1: After reset, the seed reads 0xFFFFFFFF, the polynomial reads 0x04C11DB7, the control register reads 0 and the data offset reads 0xFFFFFFFF.
- R2: A write to offset 0x10 or to offset 0x14 stores the full 32-bit word, and a later read of that offset returns it.
- R3: A control write with bit 0 set loads the running state from the seed register, so the next read of the data offset returns the seed. Control reads return bits 7:5 as last written, and every other bit, bit 0 included, reads 0.
- R4: Each write to offset 0x00 replaces the state S with the result of 32 steps, one for each bit d taken from bit 31 down to bit 0 of the ordered word. Each step shifts S left by one and XORs in the polynomial when the old S[31] differs from d. The new value is readable in the following cycle, and writes on consecutive cycles each take effect.
- R5: Control bits 6:5 set the input ordering applied before the update: 00 leaves the word unchanged, 01 reverses the bits inside each byte, 10 reverses the bits inside each 16-bit half, and 11 reverses the whole 32-bit word.
- R6: While control bit 7 is 1, data reads return the state with its bit order reversed (bit i goes to bit 31-i). Changing bit 7 without bit 0 leaves the stored state unchanged.
- R7: Writes to any offset other than 0x00, 0x08, 0x10 and 0x14 change no register or state, and reads of such offsets return 0.
- R8: bus_rdata is 0 in every cycle in which bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_re | input | 1 | Read strobe; read data is returned in the same cycle |
| bus_rdata | output | DATA_W (32) | Read data, zero when no read is active |

## Verification
A corrupted running state cannot be seen until the next read of the data offset. From then on every later result is wrong, because each update feeds on the one before it. For that reason the bench reads the data offset after nearly every data write, so an error shows within one cycle of the write that caused it. A wrong ordering mode, polynomial or seed only shows on words whose bits expose it, so every mode gets words that are not symmetric. Reloads are checked by reading back the seed directly.

// File: rtl/crc32_mmio_pkg.sv
package crc32_mmio_pkg;
   localparam int unsigned OFS_DATA = 32'h00;
   localparam int unsigned OFS_CTRL = 32'h08;
   localparam int unsigned OFS_SEED = 32'h10;
   localparam int unsigned OFS_POLY = 32'h14;

   localparam logic [31:0] SEED_RST = 32'hFFFF_FFFF;
   localparam logic [31:0] POLY_RST = 32'h04C1_1DB7;

   localparam int unsigned CTL_RELOAD  = 0;
   localparam int unsigned CTL_IN_LO   = 5;
   localparam int unsigned CTL_OUT_REV = 7;

   typedef enum logic [1:0] {
      ORD_NONE = 2'b00,
      ORD_BYTE = 2'b01,
      ORD_HALF = 2'b10,
      ORD_WORD = 2'b11
   } in_order_e;
endpackage

// File: rtl/crc32_regfile.sv
module crc32_regfile
   import crc32_mmio_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_wr,
   input  logic              poly_wr,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [2:0]        ord_wdata,
   output logic [DATA_W-1:0] seed_q,
   output logic [DATA_W-1:0] poly_q,
   output logic [2:0]        ord_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seed_q <= DATA_W'(SEED_RST);
         poly_q <= DATA_W'(POLY_RST);
         ord_q  <= 3'b000;
      end else begin
         if (seed_wr) seed_q <= wdata;
         if (poly_wr) poly_q <= wdata;
         if (ctrl_wr) ord_q  <= ord_wdata;
      end
   end

   a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
      seed_wr |=> (seed_q == $past(wdata)));
   a_r2_poly_load: assert property (@(posedge clk) disable iff (!rst_n)
      poly_wr |=> (poly_q == $past(wdata)));
endmodule

// File: rtl/crc32_in_order.sv
module crc32_in_order
   import crc32_mmio_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        mode_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int N_BYTES = DATA_W / 8;
   localparam int N_HALVES = DATA_W / 16;

   logic [DATA_W-1:0] by_byte, by_half, by_word;

   for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      for (genvar k = 0; k < 8; k++) begin : g_bit
         assign by_byte[b*8+k] = data_i[b*8+7-k];
      end
   end
   for (genvar h = 0; h < N_HALVES; h++) begin : g_half
      for (genvar k = 0; k < 16; k++) begin : g_bit
         assign by_half[h*16+k] = data_i[h*16+15-k];
      end
   end
   for (genvar k = 0; k < DATA_W; k++) begin : g_word
      assign by_word[k] = data_i[DATA_W-1-k];
   end

   always_comb begin
      unique case (in_order_e'(mode_i))
         ORD_BYTE: data_o = by_byte;
         ORD_HALF: data_o = by_half;
         ORD_WORD: data_o = by_word;
         default:  data_o = data_i;
      endcase
   end
endmodule

// File: rtl/crc32_step.sv
module crc32_step #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] state_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] poly_i,
   output logic [DATA_W-1:0] state_o
);
   logic [DATA_W-1:0] chain [0:DATA_W];

   assign chain[0] = state_i;
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb = chain[i][DATA_W-1] ^ data_i[DATA_W-1-i];
      assign chain[i+1] = {chain[i][DATA_W-2:0], 1'b0} ^ (fb ? poly_i : '0);
   end
   assign state_o = chain[DATA_W];
endmodule

// File: rtl/crc32_mmio_engine.sv
module crc32_mmio_engine
   import crc32_mmio_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata
);
   if (DATA_W % 16 != 0 || DATA_W < 16) begin : g_bad_width
      $error("crc32_mmio_engine: DATA_W must be a multiple of 16");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("crc32_mmio_engine: ADDR_W too small for the register offsets");
   end

   logic hit_data, hit_ctrl, hit_seed, hit_poly, mapped;
   assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_seed = (bus_addr == ADDR_W'(OFS_SEED));
   assign hit_poly = (bus_addr == ADDR_W'(OFS_POLY));
   assign mapped   = hit_data | hit_ctrl | hit_seed | hit_poly;

   logic data_wr, ctrl_wr, reload;
   assign data_wr = bus_we & hit_data;
   assign ctrl_wr = bus_we & hit_ctrl;
   assign reload  = ctrl_wr & bus_wdata[CTL_RELOAD];

   logic [DATA_W-1:0] seed_q, poly_q;
   logic [2:0]        ord_q;

   crc32_regfile #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .seed_wr   (bus_we & hit_seed),
      .poly_wr   (bus_we & hit_poly),
      .ctrl_wr   (ctrl_wr),
      .wdata     (bus_wdata),
      .ord_wdata (bus_wdata[CTL_OUT_REV:CTL_IN_LO]),
      .seed_q    (seed_q),
      .poly_q    (poly_q),
      .ord_q     (ord_q)
   );

   logic [DATA_W-1:0] ordered, crc_next, crc_q;

   crc32_in_order #(.DATA_W(DATA_W)) u_order (
      .data_i (bus_wdata),
      .mode_i (ord_q[1:0]),
      .data_o (ordered)
   );

   crc32_step #(.DATA_W(DATA_W)) u_step (
      .state_i (crc_q),
      .data_i  (ordered),
      .poly_i  (poly_q),
      .state_o (crc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= DATA_W'(SEED_RST);
      else if (reload)  crc_q <= seed_q;
      else if (data_wr) crc_q <= crc_next;
   end

   logic [DATA_W-1:0] crc_flip, crc_view;
   for (genvar k = 0; k < DATA_W; k++) begin : g_out_rev
      assign crc_flip[k] = crc_q[DATA_W-1-k];
   end
   assign crc_view = ord_q[2] ? crc_flip : crc_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         if (hit_data) bus_rdata = crc_view;
         if (hit_ctrl) bus_rdata[CTL_OUT_REV:CTL_IN_LO] = ord_q;
         if (hit_seed) bus_rdata = seed_q;
         if (hit_poly) bus_rdata = poly_q;
      end
   end

   // R3: reload takes the seed value held when the command was written
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (crc_q == $past(seed_q)));
   // R4: the state moves only on a data write or a reload
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_wr && !reload) |=> $stable(crc_q));
   // R6: switching the ordering fields alone keeps the state
   a_r6_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !bus_wdata[CTL_RELOAD]) |=> $stable(crc_q));
   // R7: unmapped writes touch nothing
   a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !mapped) |=> ($stable(seed_q) && $stable(poly_q) && $stable(ord_q) && $stable(crc_q)));
   // R8: idle bus reads zero
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |-> (bus_rdata == '0));
endmodule

// File: tb/crc32_mmio_engine_bench.sv
`timescale 1ns/1ps
module crc32_mmio_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;

   always #10 clk = ~clk;   // 50 MHz

   crc32_mmio_engine u_crc32_mmio_engine (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata));

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   // reference model of the registers, from the requirements
   logic [31:0] m_seed, m_poly, m_state;
   logic [2:0]  m_ord;

   function automatic logic [31:0] rev32(input logic [31:0] v);
      for (int k = 0; k < 32; k++) rev32[k] = v[31-k];
   endfunction

   function automatic logic [31:0] order_in(input logic [31:0] v, input logic [1:0] m);
      logic [31:0] r;
      r = v;
      if (m == 2'b11) r = rev32(v);
      else if (m == 2'b01) begin
         for (int b = 0; b < 4; b++) for (int k = 0; k < 8; k++) r[b*8+k] = v[b*8+7-k];
      end else if (m == 2'b10) begin
         for (int h = 0; h < 2; h++) for (int k = 0; k < 16; k++) r[h*16+k] = v[h*16+15-k];
      end
      return r;
   endfunction

   function automatic logic [31:0] crc_fold(input logic [31:0] s, input logic [31:0] d,
                                            input logic [31:0] p);
      logic [31:0] x;
      x = s;
      for (int i = 31; i >= 0; i--) begin
         if (x[31] != d[i]) x = (x << 1) ^ p;
         else               x = x << 1;
      end
      return x;
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h00:   return m_ord[2] ? rev32(m_state) : m_state;
         8'h08:   return {24'h0, m_ord, 5'h0};
         8'h10:   return m_seed;
         8'h14:   return m_poly;
         default: return 32'h0;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      case (a)
         8'h00: m_state = crc_fold(m_state, order_in(d, m_ord[1:0]), m_poly);
         8'h08: begin
            m_ord = d[7:5];
            if (d[0]) m_state = m_seed;
         end
         8'h10: m_seed = d;
         8'h14: m_poly = d;
         default: ;
      endcase
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
      bus_addr = a; bus_re = 1'b1;
      @(posedge clk); #1;
      bus_re = 1'b0;
   endtask

   // monitor: compares each read against the queued expectation
   always @(negedge clk) begin
      if (bus_re && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_vec++;
         if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s addr=%h got=%h exp=%h", t, bus_addr, bus_rdata, e);
         end
      end
   end

   task automatic idle_check();
      @(negedge clk);
      n_vec++;
      if (bus_rdata !== 32'h0) begin
         n_bad++;
         $display("FAIL R8 idle got=%h exp=00000000", bus_rdata);
      end
      @(posedge clk); #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      m_seed = 32'hFFFF_FFFF; m_poly = 32'h04C1_1DB7;
      m_state = 32'hFFFF_FFFF; m_ord = 3'b000;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset values
      rd(8'h00, "R1 data");
      rd(8'h08, "R1 ctrl");
      rd(8'h10, "R1 seed");
      rd(8'h14, "R1 poly");
      idle_check();   // R8

      // R4 plain update, default seed and polynomial, back to back writes
      wr(8'h00, 32'h6463_6261);
      rd(8'h00, "R4 single word");
      for (int i = 1; i <= 4; i++) wr(8'h00, 32'h9E37_79B9 * i);
      rd(8'h00, "R4 back-to-back words");

      // R2 seed and polynomial readback
      wr(8'h10, 32'h1234_5678);
      wr(8'h14, 32'h1EDC_6F41);
      rd(8'h10, "R2 seed");
      rd(8'h14, "R2 poly");

      // R3 reload and control readback
      wr(8'h08, 32'hFFFF_FF1F);   // reload, ordering fields zero
      rd(8'h00, "R3 reload gives seed");
      rd(8'h08, "R3 ctrl bit0 reads 0");
      wr(8'h00, 32'hDEAD_BEEF);
      rd(8'h00, "R4 new polynomial");

      // R5 each input ordering
      for (int m = 0; m < 4; m++) begin
         wr(8'h08, {24'h0, 1'b0, 2'(m), 5'h01});
         rd(8'h08, "R3 ctrl ordering fields");
         wr(8'h00, 32'h0000_0001 << (m * 7));
         wr(8'h00, 32'hC0FF_EE12);
         rd(8'h00, "R5 input ordering");
      end

      // R6 output reversal leaves the state intact
      wr(8'h08, 32'h0000_0080);
      rd(8'h00, "R6 reversed view");
      wr(8'h08, 32'h0000_0000);
      rd(8'h00, "R6 plain view after toggle");

      // reflected CRC-32 flow: all ordering bits set
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h14, 32'h04C1_1DB7);
      wr(8'h08, 32'h0000_00E1);
      rd(8'h00, "R3 reload with reversal");
      wr(8'h00, 32'h6463_6261);
      rd(8'h00, "R5 R6 reflected word");
      wr(8'h00, 32'h3433_3231);
      rd(8'h00, "R5 R6 reflected second word");

      // R7 unmapped offsets
      wr(8'h04, 32'hAAAA_AAAA);
      wr(8'h0C, 32'h5555_5555);
      wr(8'h11, 32'h0F0F_0F0F);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h80, 32'h0000_0001);
      rd(8'h00, "R7 state kept");
      rd(8'h08, "R7 ctrl kept");
      rd(8'h10, "R7 seed kept");
      rd(8'h14, "R7 poly kept");
      rd(8'h04, "R7 unmapped read");
      rd(8'h18, "R7 unmapped read");
      rd(8'h01, "R7 unaligned read");
      idle_check();   // R8

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule